// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches one pin and, when a chosen kind of edge appears on it, copies the value of a free-running 16-bit timer into a holding register. One of two timers is the source, picked by a select bit. Both timers must run on the module clock, because asynchronous timer sources are not supported. The held value is read as a high byte and a low byte. Every capture raises an interrupt request flag, and the flag stays high until software clears it.

A 4-bit mode field chooses the event. It can be every falling edge, every rising edge, or every fourth or every sixteenth rising edge through an event prescaler. The detector samples the pin level itself. When the pin is driven as an output, the output latch sets that level, so a write to the port that makes an edge starts a capture just as an external edge would. The pin level passes through a two-flop synchronizer before edge detection. A new capture overwrites an unread value without any warning.

Top module: `icap_unit`

## Requirements
- R1: The pin level is sampled at a clock edge. A change of that level reaches the capture register at the third rising clock edge after the sample. The register takes the selected timer value present at that third edge, and `cap_hi_o`/`cap_lo_o` show bits 15:8 and 7:0 of it.
- R2: With mode 4'b0100, every falling edge of the pin level makes a capture, and rising edges make none.
- R3: With mode 4'b0101, every rising edge makes a capture, and falling edges make none.
- R4: A capture sets `flag_o` in the same cycle that the register loads. The flag then stays high until `flag_clr_i` is sampled high.
- R5: If `flag_clr_i` is high in the cycle a capture loads, the flag stays high. A clear without a capture drops the flag at the next edge.
- R6: When `tsel_i` is 0 the source is `timer_a_i`, and when it is 1 the source is `timer_b_i`.
- R7: Any mode value outside 4'b0100 to 4'b0111 disables capture. The register and the flag are then left unchanged by pin edges.
- R8: With mode 4'b0110, every fourth rising edge makes a capture, counted from the last capture or from the last restart.
- R9: With mode 4'b0111, every sixteenth rising edge makes a capture, counted the same way.
- R10: A capture that comes before the last value has been read overwrites it. There is no error indication.
- R11: The rising-edge count restarts from zero when the mode field changes or when the mode is not a prescaled one. The first prescaled capture after such a change therefore needs a full four or sixteen rising edges.
- R12: When `pad_oe_i` is 1, the level seen is `pad_out_i` and `pad_i` has no effect. An edge written to `pad_out_i` then makes a capture.
- R13: After reset the capture register reads zero and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Event mode select |
| tsel_i | input | 1 | Timer source select |
| timer_a_i | input | 16 | First timer count |
| timer_b_i | input | 16 | Second timer count |
| pad_i | input | 1 | External pin level |
| pad_oe_i | input | 1 | Pin driven as output |
| pad_out_i | input | 1 | Output latch value |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| cap_hi_o | output | 8 | Captured value, high byte |
| cap_lo_o | output | 8 | Captured value, low byte |
| flag_o | output | 1 | Capture interrupt request flag |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. A qualified event loads the selected timer and raises the flag. The flag holds until cleared, a lone clear drops it, and a disabled mode leaves the register frozen. Other behaviours only show over whole edge sequences, and the bench's scenarios cover those. These include the counting of every fourth and sixteenth rising edge and the count restart on a mode change. They also include the fall-only and rise-only selection, the output-latch path and the exact three-edge latency. The bench sweeps all sixteen mode codes with both timer sources against an arithmetic model.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int unsigned TIMER_W = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned MODE_W  = 4;

    localparam logic [MODE_W-1:0] MODE_FALL    = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_RISE    = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_RISE_A  = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_RISE_B  = 4'b0111;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic mode_is_prescaled(input logic [MODE_W-1:0] m);
        return (m == MODE_RISE_A) || (m == MODE_RISE_B);
    endfunction

    function automatic logic mode_is_valid(input logic [MODE_W-1:0] m);
        return (m == MODE_FALL) || (m == MODE_RISE) || mode_is_prescaled(m);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_i,
    output icap_pkg::edge_t   edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= lvl_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        edge_o.rise = chain_q[STAGES-1] & ~prev_q;
        edge_o.fall = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/icap_qual.sv
module icap_qual
    import icap_pkg::*;
#(
    parameter int unsigned DIV_A = 4,
    parameter int unsigned DIV_B = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  edge_t             edge_i,
    output logic              ev_o
);
    localparam int unsigned CW = $clog2(DIV_B);

    logic [MODE_W-1:0] mode_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_d;
    logic [CW-1:0]     limit;
    logic              mode_chg;
    logic              pre;
    logic              at_limit;

    always_comb begin
        mode_chg = (mode_i != mode_q);
        pre      = mode_is_prescaled(mode_i);
        limit    = (mode_i == MODE_RISE_A) ? CW'(DIV_A - 1) : CW'(DIV_B - 1);
        at_limit = (cnt_q == limit);
    end

    always_comb begin
        unique case (mode_i)
            MODE_FALL:   ev_o = edge_i.fall;
            MODE_RISE:   ev_o = edge_i.rise;
            MODE_RISE_A,
            MODE_RISE_B: ev_o = edge_i.rise & ~mode_chg & at_limit;
            default:     ev_o = 1'b0;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (mode_chg || !pre) begin
            cnt_d = '0;
        end else if (edge_i.rise) begin
            cnt_d = at_limit ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_i;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/icap_hold.sv
module icap_hold
    import icap_pkg::*;
#(
    parameter int unsigned TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_i,
    input  logic          tsel_i,
    input  logic [TW-1:0] timer_a_i,
    input  logic [TW-1:0] timer_b_i,
    input  logic          clr_i,
    output logic [TW-1:0] cap_o,
    output logic          flag_o
);
    logic [TW-1:0] src;

    always_comb src = tsel_i ? timer_b_i : timer_a_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (ev_i) cap_o <= src;
            if (ev_i)       flag_o <= 1'b1;
            else if (clr_i) flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_A       = 4,
    parameter int unsigned DIV_B       = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               tsel_i,
    input  logic [TIMER_W-1:0] timer_a_i,
    input  logic [TIMER_W-1:0] timer_b_i,
    input  logic               pad_i,
    input  logic               pad_oe_i,
    input  logic               pad_out_i,
    input  logic               flag_clr_i,
    output logic [BYTE_W-1:0]  cap_hi_o,
    output logic [BYTE_W-1:0]  cap_lo_o,
    output logic               flag_o
);
    logic               pin_lvl;
    edge_t              edges;
    logic               cap_ev;
    logic [TIMER_W-1:0] cap_q;

    // The detector follows the pin level, including when it is driven
    always_comb pin_lvl = pad_oe_i ? pad_out_i : pad_i;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (pin_lvl),
        .edge_o (edges)
    );

    icap_qual #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .edge_i (edges),
        .ev_o   (cap_ev)
    );

    icap_hold #(.TW(TIMER_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (cap_ev),
        .tsel_i    (tsel_i),
        .timer_a_i (timer_a_i),
        .timer_b_i (timer_b_i),
        .clr_i     (flag_clr_i),
        .cap_o     (cap_q),
        .flag_o    (flag_o)
    );

    always_comb begin
        cap_hi_o = cap_q[TIMER_W-1 -: BYTE_W];
        cap_lo_o = cap_q[BYTE_W-1:0];
    end
endmodule

// File: rtl/icap_checker.sv
module icap_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  mode_i,
    input logic        tsel_i,
    input logic [15:0] timer_a_i,
    input logic [15:0] timer_b_i,
    input logic        flag_clr_i,
    input logic        cap_ev,
    input logic [7:0]  cap_hi_o,
    input logic [7:0]  cap_lo_o,
    input logic        flag_o
);
    logic [15:0] cap_word;
    logic        mode_ok;

    always_comb begin
        cap_word = {cap_hi_o, cap_lo_o};
        mode_ok  = (mode_i[3:2] == 2'b01);
    end

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> cap_word == $past(tsel_i ? timer_b_i : timer_a_i)); // R1

    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> flag_o); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_clr_i) |=> flag_o); // R4

    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !cap_ev) |=> !flag_o); // R5

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> $stable(cap_word)); // R7

    AST_NO_EVENT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |-> !cap_ev); // R7
endmodule

bind icap_unit icap_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .tsel_i     (tsel_i),
    .timer_a_i  (timer_a_i),
    .timer_b_i  (timer_b_i),
    .flag_clr_i (flag_clr_i),
    .cap_ev     (cap_ev),
    .cap_hi_o   (cap_hi_o),
    .cap_lo_o   (cap_lo_o),
    .flag_o     (flag_o)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'd0;
    logic        tsel = 1'b0;
    logic [15:0] ta = 16'd0;
    logic [15:0] tb = 16'd0;
    logic        pad = 1'b0;
    logic        oe = 1'b0;
    logic        pout = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic        flag;

    int errors = 0;
    int checks = 0;

    // model state
    logic        lvl = 1'b0;
    logic [15:0] exp_cap = 16'd0;
    logic        exp_flag = 1'b0;
    int          cnt = 0;
    logic [3:0]  cur_mode = 4'd0;
    int          seed = 0;

    always #10 clk = ~clk;

    icap_unit dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .tsel_i(tsel),
        .timer_a_i(ta), .timer_b_i(tb), .pad_i(pad), .pad_oe_i(oe),
        .pad_out_i(pout), .flag_clr_i(clr),
        .cap_hi_o(hi), .cap_lo_o(lo), .flag_o(flag)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got=hung exp=done");
        report();
    end

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({hi, lo}, exp_cap, req);
        check({15'd0, flag}, {15'd0, exp_flag}, {req, "/R4 flag"});
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode = m;
        // R11: count restarts on change or outside prescaled modes
        if (m != cur_mode || !(m == 4'b0110 || m == 4'b0111)) cnt = 0;
        cur_mode = m;
        repeat (2) @(negedge clk);
    endtask

    // Update model for a level change on the pin
    task automatic model_edge(input logic v);
        logic rise;
        logic fall;
        logic cap;
        rise = v & ~lvl;
        fall = ~v & lvl;
        lvl = v;
        cap = 1'b0;
        case (cur_mode)
            4'b0100: cap = fall;
            4'b0101: cap = rise;
            4'b0110, 4'b0111: if (rise) begin
                cnt++;
                if (cnt == ((cur_mode == 4'b0110) ? 4 : 16)) begin
                    cap = 1'b1;
                    cnt = 0;
                end
            end
            default: cap = 1'b0;
        endcase
        if (cap) begin
            exp_cap = tsel ? tb : ta;
            exp_flag = 1'b1;
        end
    endtask

    // Drive a pin level (pad or output latch), let it settle, check
    task automatic apply(input logic v, input logic via_latch, input string req);
        @(negedge clk);
        seed++;
        ta = 16'(seed * 977 + 13);
        tb = ta ^ 16'hA5C3;
        if (via_latch) pout = v;
        else pad = v;
        model_edge(v);
        repeat (4) @(negedge clk);
        check_all(req);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_flag = 1'b0;
        @(negedge clk);
        check({15'd0, flag}, 16'd0, "R5 clear alone");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R13 reset state");

        // Exhaustive mode sweep with both timer sources
        for (int m = 0; m < 16; m++) begin
            for (int ts = 0; ts < 2; ts++) begin
                set_mode(4'd0);
                set_mode(4'(m));
                tsel = ts[0];
                for (int e = 0; e < 34; e++) begin
                    apply(~lvl, 1'b0, "R1/R2/R3/R6/R7/R8/R9/R10 sweep");
                    if (e % 5 == 4) clear_flag();
                end
            end
        end

        // R11: partial prescale count then mode change restarts counting
        set_mode(4'b0110);
        tsel = 1'b0;
        if (lvl) apply(1'b0, 1'b0, "R11 setup");
        for (int e = 0; e < 4; e++) apply(~lvl, 1'b0, "R11 partial");
        set_mode(4'b0111);
        set_mode(4'b0110);
        for (int e = 0; e < 8; e++) apply(~lvl, 1'b0, "R11 restart after change");
        set_mode(4'b0011);
        set_mode(4'b0110);
        for (int e = 0; e < 8; e++) apply(~lvl, 1'b0, "R11 restart after disable");

        // R5: clear and capture in the same cycle
        set_mode(4'b0101);
        if (lvl) apply(1'b0, 1'b0, "R5 setup");
        clear_flag();
        @(negedge clk);
        ta = 16'h5A3C;
        pad = 1'b1;
        model_edge(1'b1);
        @(negedge clk);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        check({15'd0, flag}, 16'd1, "R5 capture beats clear");
        check({hi, lo}, 16'h5A3C, "R5 value");
        clear_flag();

        // R12: pin driven as output, pad ignored, latch writes capture
        set_mode(4'b0101);
        pout = lvl;
        @(negedge clk);
        oe = 1'b1;
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            pad = ~pad;
            repeat (4) @(negedge clk);
            check_all("R12 pad ignored");
        end
        for (int e = 0; e < 6; e++) apply(~lvl, 1'b1, "R12 latch write captures");
        pad = lvl;
        @(negedge clk);
        oe = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R12 back to pad");

        report();
    end
endmodule